// File: doc/BRIEF.md
# Warp Divergence Lane-Mask Stack

This block tracks which lanes of one warp may commit results while the warp runs through nested if/else regions. Every lane executes every instruction. The block only produces the active mask that gates each lane's write-back.

A branch marker arrives on a 2-bit command input, together with a per-lane predicate vector. There are three markers:
- **Push** enters a divergent region. The current mask is saved and the mask narrows to the lanes whose predicate is set.
- **Complement** switches to the other side of the branch. The lanes that were active before the branch but not on the taken side become active.
- **Pop** leaves the region at reconvergence. The saved mask comes back.

The saved masks sit in a last-in, first-out stack whose depth is a parameter. Pushing onto a full stack, or popping or complementing with an empty stack, is refused and reported.

Top module: `wmask_stack`

## Requirements
- R1: While reset is held, and until the first accepted command, the active mask is all ones, the stack is empty, and both error outputs are low.
- R2: Command code 2'b00 (idle) leaves the active mask and the stack unchanged, whatever the predicate.
- R3: Command code 2'b01 (push) with fewer than DEPTH saved masks does two things. It saves the current mask on top of the stack. It sets the mask to the old mask AND the predicate, visible on the cycle after the command.
- R4: Command code 2'b10 (complement) with a non-empty stack sets the mask to the top saved mask AND NOT the current mask. The stack is left unchanged. The result is visible on the cycle after the command.
- R5: Command code 2'b11 (pop) with a non-empty stack restores the top saved mask as the active mask and removes it from the stack. The result is visible on the cycle after the command.
- R6: Saved masks come back in last-in, first-out order across nesting up to DEPTH levels.
- R7: A push while DEPTH masks are saved raises overflowErr for exactly the following cycle. It leaves the mask and the stack unchanged.
- R8: A pop or complement with an empty stack raises underflowErr for exactly the following cycle. It leaves the mask and the stack unchanged.
- R9: After any command that is accepted, and after idle, both error outputs are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| brCmd | input | 2 | Branch marker: 00 idle, 01 push, 10 complement, 11 pop |
| lanePred | input | LANES | Per-lane predicate, used by push |
| activeMask | output | LANES | Lanes allowed to commit results |
| overflowErr | output | 1 | One-cycle pulse: push refused on a full stack |
| underflowErr | output | 1 | One-cycle pulse: pop or complement refused on an empty stack |

## Verification
Every result of this block comes from one register stage. The new mask and both error pulses are due exactly one cycle after the command is presented, and nothing later depends on that command except through the stack contents. The bench drives a command on a falling edge. On the next falling edge it compares all three outputs with a behavioural queue model that was advanced when the command was driven. So each comparison lands one rising edge after its stimulus, and every cycle of the run is checked, including idle cycles and refused commands.

// File: rtl/wmask_pkg.sv
`timescale 1ns/1ps
package wmask_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_PUSH = 2'b01,
    CMD_FLIP = 2'b10,
    CMD_POP  = 2'b11
  } brCmd_e;

  // strobes from control to the mask datapath
  typedef struct packed {
    logic push;
    logic flip;
    logic pop;
  } stkStrobe_t;

endpackage

// File: rtl/wmask_ctrl.sv
`timescale 1ns/1ps
module wmask_ctrl
  import wmask_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  brCmd_e        cmd,
  output stkStrobe_t    strobe,
  output logic [CW-1:0] depthCnt,
  output logic          ovfErr,
  output logic          udfErr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic stkFull;
  logic stkEmpty;
  logic [CW-1:0] cntQ;

  assign stkFull  = (cntQ == FULL_CNT);
  assign stkEmpty = (cntQ == '0);

  // decide which stack action, if any, is legal this cycle
  always_comb begin
    strobe = '0;
    unique case (cmd)
      CMD_PUSH: strobe.push = !stkFull;
      CMD_FLIP: strobe.flip = !stkEmpty;
      CMD_POP:  strobe.pop  = !stkEmpty;
      default:  strobe      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      ovfErr <= 1'b0;
      udfErr <= 1'b0;
    end else begin
      if (strobe.push)      cntQ <= cntQ + 1'b1;
      else if (strobe.pop)  cntQ <= cntQ - 1'b1;
      ovfErr <= (cmd == CMD_PUSH) && stkFull;
      udfErr <= ((cmd == CMD_POP) || (cmd == CMD_FLIP)) && stkEmpty;
    end
  end

  assign depthCnt = cntQ;

endmodule

// File: rtl/wmask_dp.sv
`timescale 1ns/1ps
module wmask_dp
  import wmask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stkStrobe_t       strobe,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] mask
);

  // entry 0 is the top of stack; the stack shifts on push and pop
  logic [LANES-1:0] stkQ [DEPTH];
  logic [LANES-1:0] maskQ;
  logic [LANES-1:0] topMask;

  assign topMask = stkQ[0];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [LANES-1:0] shiftIn;
    logic [LANES-1:0] shiftOut;

    if (e == 0) begin : g_head
      assign shiftIn = maskQ;
    end else begin : g_body
      assign shiftIn = stkQ[e-1];
    end

    if (e == DEPTH - 1) begin : g_tail
      assign shiftOut = '0;
    end else begin : g_mid
      assign shiftOut = stkQ[e+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN)            stkQ[e] <= '0;
      else if (strobe.push) stkQ[e] <= shiftIn;
      else if (strobe.pop)  stkQ[e] <= shiftOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '1;
    else if (strobe.push) maskQ <= maskQ & pred;
    else if (strobe.flip) maskQ <= topMask & ~maskQ;
    else if (strobe.pop)  maskQ <= topMask;
  end

  assign mask = maskQ;

endmodule

// File: rtl/wmask_stack.sv
`timescale 1ns/1ps
module wmask_stack
  import wmask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       brCmd,
  input  logic [LANES-1:0] lanePred,
  output logic [LANES-1:0] activeMask,
  output logic             overflowErr,
  output logic             underflowErr
);

  localparam int CW = $clog2(DEPTH + 1);

  stkStrobe_t    strobe;
  logic [CW-1:0] depthCnt;

  wmask_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (brCmd_e'(brCmd)),
    .strobe   (strobe),
    .depthCnt (depthCnt),
    .ovfErr   (overflowErr),
    .udfErr   (underflowErr)
  );

  wmask_dp #(.LANES(LANES), .DEPTH(DEPTH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pred   (lanePred),
    .mask   (activeMask)
  );

endmodule

// File: rtl/wmask_chk.sv
`timescale 1ns/1ps
module wmask_chk #(
  parameter  int LANES = 32,
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       brCmd,
  input logic [LANES-1:0] lanePred,
  input logic [LANES-1:0] activeMask,
  input logic             overflowErr,
  input logic             underflowErr,
  input logic [CW-1:0]    depthCnt
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    brCmd == 2'b00 |=> $stable(activeMask));

  // R3
  push_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brCmd == 2'b01 && depthCnt != FULL_CNT) |=>
      activeMask == ($past(activeMask) & $past(lanePred)));

  // R4
  flip_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brCmd == 2'b10 && depthCnt != '0) |=>
      (activeMask & $past(activeMask)) == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brCmd == 2'b01 && depthCnt == FULL_CNT) |=>
      overflowErr && $stable(activeMask) && $stable(depthCnt));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((brCmd == 2'b11 || brCmd == 2'b10) && depthCnt == '0) |=>
      underflowErr && $stable(activeMask) && $stable(depthCnt));

  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    brCmd == 2'b00 |=> !overflowErr && !underflowErr);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthCnt <= FULL_CNT);

endmodule

bind wmask_stack wmask_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .brCmd        (brCmd),
  .lanePred     (lanePred),
  .activeMask   (activeMask),
  .overflowErr  (overflowErr),
  .underflowErr (underflowErr),
  .depthCnt     (depthCnt)
);

// File: tb/wmask_stack_tb_top.sv
`timescale 1ns/1ps
module wmask_stack_tb_top;

  localparam int LANES = 32;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       brCmd = 2'b00;
  logic [LANES-1:0] lanePred = '0;
  logic [LANES-1:0] activeMask;
  logic             overflowErr;
  logic             underflowErr;

  always #5 clk = ~clk;

  wmask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .brCmd        (brCmd),
    .lanePred     (lanePred),
    .activeMask   (activeMask),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  // behavioural reference: queue of saved masks, front is top
  logic [LANES-1:0] mdlMask = '1;
  logic [LANES-1:0] mdlStk[$];
  logic             mdlOvf = 1'b0;
  logic             mdlUdf = 1'b0;
  string            expTag = "R1";

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done = 1'b0;

  task automatic compare();
    string flagTag;
    flagTag = (mdlOvf || mdlUdf) ? expTag : "R9";
    testCnt++;
    if (activeMask !== mdlMask) begin
      failCnt++;
      $display("FAIL %s activeMask actual=%h expected=%h", expTag, activeMask, mdlMask);
    end
    testCnt++;
    if (overflowErr !== mdlOvf) begin
      failCnt++;
      $display("FAIL %s overflowErr actual=%b expected=%b",
               mdlOvf ? expTag : flagTag, overflowErr, mdlOvf);
    end
    testCnt++;
    if (underflowErr !== mdlUdf) begin
      failCnt++;
      $display("FAIL %s underflowErr actual=%b expected=%b",
               mdlUdf ? expTag : flagTag, underflowErr, mdlUdf);
    end
  endtask

  // check the outputs due from the previous command, then drive the next one
  task automatic step(input logic [1:0] c, input logic [LANES-1:0] p, input string tagHint = "");
    @(negedge clk);
    compare();
    brCmd    = c;
    lanePred = p;
    mdlOvf   = 1'b0;
    mdlUdf   = 1'b0;
    case (c)
      2'b01: begin
        if (mdlStk.size() >= DEPTH) begin
          mdlOvf = 1'b1; expTag = "R7";
        end else begin
          mdlStk.push_front(mdlMask);
          mdlMask = mdlMask & p; expTag = "R3";
        end
      end
      2'b10: begin
        if (mdlStk.size() == 0) begin
          mdlUdf = 1'b1; expTag = "R8";
        end else begin
          mdlMask = mdlStk[0] & ~mdlMask; expTag = "R4";
        end
      end
      2'b11: begin
        if (mdlStk.size() == 0) begin
          mdlUdf = 1'b1; expTag = "R8";
        end else begin
          mdlMask = mdlStk.pop_front(); expTag = "R5";
        end
      end
      default: expTag = "R2";
    endcase
    if (tagHint != "") expTag = tagHint;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state is checked by the first compare
    expTag = "R1";
    step(2'b00, 32'hDEAD_BEEF);        // R2 idle with a busy predicate
    step(2'b00, 32'h0000_0000);
    // R6 nested if/else with LIFO restore
    step(2'b01, 32'h0000_FFFF, "R6");
    step(2'b01, 32'h00FF_00FF, "R6");
    step(2'b10, 32'h1234_5678, "R6");
    step(2'b11, 32'h0, "R6");
    step(2'b10, 32'h0, "R6");
    step(2'b11, 32'h0, "R6");
    // R7 overflow: fill the stack then push once more
    step(2'b01, 32'hFFFF_FFF0);
    step(2'b01, 32'hF0F0_F0F0);
    step(2'b01, 32'hCCCC_CCCC);
    step(2'b01, 32'hAAAA_AAAA);
    step(2'b01, 32'h0000_0001);
    step(2'b00, 32'h0);
    // R5 drain, then R8 underflow on pop and complement
    for (int i = 0; i < DEPTH; i++) step(2'b11, 32'h0);
    step(2'b11, 32'h0);
    step(2'b10, 32'h0);
    step(2'b00, 32'h0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) step(2'($urandom % 4), $urandom);
    step(2'b00, 32'h0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule